// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block carries software-generated interrupts between the CPUs of a small multiprocessor cluster. A CPU that wants to signal others presents one request: its own CPU number, an interrupt number from 0 to 15, and a mask of the CPUs to be interrupted. For every CPU in the mask, the block records a pending flag. The flag is kept separately for each combination of receiving CPU, sending CPU and interrupt number. Every flag therefore stands for one event. Each request is a single edge event, and every CPU in the mask sees the same interrupt number.

Each receiving CPU has its own interrupt line and its own acknowledge path. The line is high while that CPU has anything pending. A read strobe on the acknowledge path returns one packed result one cycle later and retires the chosen flag. The result holds the sender's CPU number and the interrupt number. If nothing is pending, the result is the spurious code.

Each receiving CPU has a small state machine with three states. ST_IDLE means nothing is pending. ST_PEND means at least one flag is pending. ST_RESP is the single cycle in which an acknowledge result is presented. The transitions are as follows:
- A read strobe in any state moves to ST_RESP.
- Without a strobe, the machine moves to ST_PEND if the pending set after the edge is non-empty.
- Without a strobe and with an empty pending set, it moves to ST_IDLE.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, no flag is pending, every `irq` bit is 0 and every `ack_valid` bit is 0.
- R2: A request with `req_valid`=1 from a connected sender sets the flag (target t, sender `req_src`, number `req_id`) for every bit t set in `req_targets`, and `irq[t]` is 1 after that clock edge.
- R3: A request whose `req_src` is not below NUM_CPU is ignored, so no `irq` bit rises because of it.
- R4: A request for a flag that is already pending merges with it, and only one acknowledge returns that event.
- R5: The acknowledge result for target t is in `ack_data[13*t +: 13]`. Bits 12:10 hold the sender's CPU number and bits 9:0 hold the interrupt number.
- R6: The acknowledge chooses the lowest pending interrupt number first, and among senders of that number it chooses the lowest sender first.
- R7: An acknowledge with nothing pending returns 1023 in bits 9:0 and 0 in bits 12:10, and it changes no state.
- R8: `ack_valid[t]` is 1 in exactly the cycle after a cycle with `ack_rd[t]`=1. The acknowledged flag is cleared at the same edge that samples the strobe.
- R9: If a request sets the same flag that is being acknowledged on the same edge, that flag stays pending.
- R10: `irq[t]` is 1 exactly when target t has at least one pending flag.
- R11: The sender field of a valid acknowledge is always below NUM_CPU, so in a single-CPU build it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle generation request |
| req_src | input | 3 | CPU number of the requester |
| req_id | input | 4 | Interrupt number, 0 to 15 |
| req_targets | input | NUM_CPU | Mask of receiving CPUs |
| ack_rd | input | NUM_CPU | Per-CPU acknowledge read strobe |
| irq | output | NUM_CPU | Per-CPU interrupt line |
| ack_valid | output | NUM_CPU | Acknowledge result valid, one cycle after the strobe |
| ack_data | output | 13*NUM_CPU | Packed acknowledge results, 13 bits per CPU |

## Verification
The assertions check the following on every cycle:
- The response strobe follows each read by exactly one cycle.
- A valid request raises the interrupt line of each target.
- A line that is low stays low unless a connected sender targets it, which covers the ignored senders.
- Every valid result carries a sender below NUM_CPU and a number that is either in range or the spurious code.

Only the bench's scenarios can show the rest: the order in which results come out, the merging of duplicate requests, the survival of a flag that is set and acknowledged on the same edge, and the exact packed values. The bench compares these against a model of the banked pending flags. The scenarios are full sweeps over every sender and number, with and without acknowledges running at the same time.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int SGI_N   = 16;
    localparam int NUM_W   = 4;
    localparam int SRC_W   = 3;
    localparam int IDF_W   = 10;
    localparam int ACK_W   = SRC_W + IDF_W;
    localparam logic [IDF_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_RESP = 2'd2
    } tgt_state_e;

    function automatic logic [ACK_W-1:0] pack_ack(input logic [SRC_W-1:0] src,
                                                  input logic [NUM_W-1:0] num);
        return {src, {(IDF_W-NUM_W){1'b0}}, num};
    endfunction
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int BANK_W = NUM_CPU * SGI_N
) (
    input  logic                             req_valid,
    input  logic [SRC_W-1:0]                 req_src,
    input  logic [NUM_W-1:0]                 req_id,
    input  logic [NUM_CPU-1:0]               req_targets,
    output logic [NUM_CPU-1:0][BANK_W-1:0]   set_o
);
    localparam logic [SRC_W:0] NCPU_L = NUM_CPU[SRC_W:0];

    logic               connected;
    logic [BANK_W-1:0]  one_hot;

    always_comb begin
        connected = req_valid && ({1'b0, req_src} < NCPU_L);
        one_hot   = '0;
        for (int s = 0; s < NUM_CPU; s++) begin
            for (int n = 0; n < SGI_N; n++) begin
                if (req_src == s[SRC_W-1:0] && req_id == n[NUM_W-1:0])
                    one_hot[s*SGI_N + n] = 1'b1;
            end
        end
    end

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
        assign set_o[t] = (connected && req_targets[t]) ? one_hot : '0;
    end
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int BANK_W = NUM_CPU * SGI_N
) (
    input  logic [BANK_W-1:0] pend_i,
    output logic              hit_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [NUM_W-1:0]  num_o
);
    always_comb begin
        hit_o = 1'b0;
        src_o = '0;
        num_o = '0;
        for (int n = SGI_N - 1; n >= 0; n--) begin
            for (int s = NUM_CPU - 1; s >= 0; s--) begin
                if (pend_i[s*SGI_N + n]) begin
                    hit_o = 1'b1;
                    src_o = s[SRC_W-1:0];
                    num_o = n[NUM_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/sgi_bank.sv
module sgi_bank
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int BANK_W = NUM_CPU * SGI_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] set_i,
    input  logic              ack_rd_i,
    output logic              irq_o,
    output logic              ack_valid_o,
    output logic [ACK_W-1:0]  ack_data_o
);
    tgt_state_e        state_q, state_d;
    logic [BANK_W-1:0] pend_q, pend_d, clr;
    logic [ACK_W-1:0]  data_q, data_d;
    logic              hit;
    logic [SRC_W-1:0]  win_src;
    logic [NUM_W-1:0]  win_num;

    sgi_pick #(.NUM_CPU(NUM_CPU)) u_pick (
        .pend_i (pend_q),
        .hit_o  (hit),
        .src_o  (win_src),
        .num_o  (win_num)
    );

    always_comb begin
        clr = '0;
        for (int b = 0; b < BANK_W; b++) begin
            if (ack_rd_i && hit && (b == int'(win_src) * SGI_N + int'(win_num)))
                clr[b] = 1'b1;
        end
        pend_d = (pend_q & ~clr) | set_i;
        data_d = data_q;
        if (ack_rd_i)
            data_d = hit ? pack_ack(win_src, win_num) : {{SRC_W{1'b0}}, SPURIOUS_ID};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PEND, ST_RESP: begin
                if (ack_rd_i)
                    state_d = ST_RESP;
                else if (|pend_d)
                    state_d = ST_PEND;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            data_q  <= {{SRC_W{1'b0}}, SPURIOUS_ID};
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            data_q  <= data_d;
        end
    end

    always_comb begin
        irq_o       = |pend_q;
        ack_valid_o = 1'b0;
        unique case (state_q)
            ST_RESP:          ack_valid_o = 1'b1;
            ST_IDLE, ST_PEND: ack_valid_o = 1'b0;
            default:          ack_valid_o = 1'b0;
        endcase
        ack_data_o = data_q;
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_src,
    input  logic [3:0]               req_id,
    input  logic [NUM_CPU-1:0]       req_targets,
    input  logic [NUM_CPU-1:0]       ack_rd,
    output logic [NUM_CPU-1:0]       irq,
    output logic [NUM_CPU-1:0]       ack_valid,
    output logic [13*NUM_CPU-1:0]    ack_data
);
    localparam int BANK_W = NUM_CPU * SGI_N;

    logic [NUM_CPU-1:0][BANK_W-1:0] set_vec;

    sgi_req_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .req_valid   (req_valid),
        .req_src     (req_src),
        .req_id      (req_id),
        .req_targets (req_targets),
        .set_o       (set_vec)
    );

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_bank
        sgi_bank #(.NUM_CPU(NUM_CPU)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (set_vec[t]),
            .ack_rd_i    (ack_rd[t]),
            .irq_o       (irq[t]),
            .ack_valid_o (ack_valid[t]),
            .ack_data_o  (ack_data[t*ACK_W +: ACK_W])
        );
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NUM_CPU = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [2:0]            req_src,
    input logic [3:0]            req_id,
    input logic [NUM_CPU-1:0]    req_targets,
    input logic [NUM_CPU-1:0]    ack_rd,
    input logic [NUM_CPU-1:0]    irq,
    input logic [NUM_CPU-1:0]    ack_valid,
    input logic [13*NUM_CPU-1:0] ack_data
);
    localparam logic [3:0] NCPU_L = NUM_CPU[3:0];

    logic real_req;
    assign real_req = req_valid && ({1'b0, req_src} < NCPU_L);

    for (genvar t = 0; t < NUM_CPU; t++) begin : g_t
        logic [2:0] f_src;
        logic [9:0] f_num;
        assign f_src = ack_data[t*13 + 10 +: 3];
        assign f_num = ack_data[t*13 +: 10];

        p_resp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ack_rd[t] |=> ack_valid[t]);
        p_no_stray_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_rd[t] |=> !ack_valid[t]);
        p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (real_req && req_targets[t]) |=> irq[t]);
        p_ghost_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq[t] && !(real_req && req_targets[t])) |=> !irq[t]);
        p_src_field_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ack_valid[t] |-> ({1'b0, f_src} < NCPU_L));
        p_num_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ack_valid[t] |-> (f_num < 10'd16 || f_num == 10'd1023));
        p_spurious_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid[t] && f_num == 10'd1023) |-> (f_src == 3'd0));
    end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_src     (req_src),
    .req_id      (req_id),
    .req_targets (req_targets),
    .ack_rd      (ack_rd),
    .irq         (irq),
    .ack_valid   (ack_valid),
    .ack_data    (ack_data)
);

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;
    localparam int NC = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_src = '0;
    logic [3:0]      req_id = '0;
    logic [NC-1:0]   req_targets = '0;
    logic [NC-1:0]   ack_rd = '0;
    logic [NC-1:0]   irq;
    logic [NC-1:0]   ack_valid;
    logic [13*NC-1:0] ack_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit pm [NC][NC][16];

    always #2 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NC)) i_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_id(req_id), .req_targets(req_targets), .ack_rd(ack_rd),
        .irq(irq), .ack_valid(ack_valid), .ack_data(ack_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ack(input int t);
        for (int n = 0; n < 16; n++)
            for (int s = 0; s < NC; s++)
                if (pm[t][s][n]) return (s << 10) | n;
        return 1023;
    endfunction

    task automatic cycle(input bit rv, input int src, input int id,
                         input logic [NC-1:0] mask, input logic [NC-1:0] ack,
                         input string tag);
        int exp_d [NC];
        @(negedge clk);
        req_valid = rv; req_src = src[2:0]; req_id = id[3:0];
        req_targets = mask; ack_rd = ack;
        @(posedge clk);
        #1;
        for (int t = 0; t < NC; t++) begin
            exp_d[t] = exp_ack(t);
            if (ack[t] && exp_d[t] != 1023) pm[t][exp_d[t] >> 10][exp_d[t] & 15] = 0;
        end
        if (rv && src < NC)
            for (int t = 0; t < NC; t++) if (mask[t]) pm[t][src][id] = 1;
        for (int t = 0; t < NC; t++) begin
            bit any = 0;
            for (int s = 0; s < NC; s++) for (int n = 0; n < 16; n++) any |= pm[t][s][n];
            chk(irq[t] == any, {tag, " R10 irq"}, int'(irq[t]), int'(any));
            chk(ack_valid[t] == ack[t], {tag, " R8 ack_valid"}, int'(ack_valid[t]), int'(ack[t]));
            if (ack[t]) begin
                chk(int'(ack_data[t*13 +: 13]) == exp_d[t], {tag, " R5 ack_data"},
                    int'(ack_data[t*13 +: 13]), exp_d[t]);
                chk(int'(ack_data[t*13 + 10 +: 3]) < NC, {tag, " R11 src field"},
                    int'(ack_data[t*13 + 10 +: 3]), 0);
            end
        end
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 4 * 16 + 2; k++) cycle(0, 0, 0, '0, '1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(irq == '0, "R1 irq after reset", int'(irq), 0);
        chk(ack_valid == '0, "R1 ack_valid after reset", int'(ack_valid), 0);
        rst_n = 1'b1;

        // R7: empty acknowledge returns spurious code
        cycle(0, 0, 0, '0, 4'b1111, "R7");
        // R3: unconnected senders ignored
        for (int s = NC; s < 8; s++) cycle(1, s, s, 4'b1111, '0, "R3");
        // R4: merged duplicate, one acknowledge then spurious
        cycle(1, 1, 5, 4'b0001, '0, "R4");
        cycle(1, 1, 5, 4'b0001, '0, "R4");
        cycle(0, 0, 0, '0, 4'b0001, "R4");
        cycle(0, 0, 0, '0, 4'b0001, "R4");
        // R9: set and acknowledge of the same flag on one edge
        cycle(1, 2, 3, 4'b0001, '0, "R9");
        cycle(1, 2, 3, 4'b0001, 4'b0001, "R9");
        cycle(0, 0, 0, '0, 4'b0001, "R9");
        cycle(0, 0, 0, '0, 4'b0001, "R9");
        // R6: same number from several senders, lowest sender first
        cycle(1, 3, 7, 4'b0010, '0, "R6");
        cycle(1, 0, 7, 4'b0010, '0, "R6");
        cycle(1, 2, 9, 4'b0010, '0, "R6");
        cycle(1, 1, 2, 4'b0010, '0, "R6");
        drain("R6 order");

        // R2: full sweep of senders and numbers, then drain
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 16; i++)
                cycle(1, s, i, 4'((s * 5 + i * 3 + 1) % 16), '0, "R2 sweep");
        drain("R6 sweep drain");

        // R2/R6: sweep with acknowledges running alongside
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 16; i++)
                cycle(1, s, i, 4'((s * 7 + i + 3) % 16), 4'((s + i * 5) % 16), "R2 mixed");
        drain("R6 mixed drain");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule